// File: doc/BRIEF.md
# Runtime-Width Saturation Clamp

This block clamps a 33-bit two's-complement operand into a target field of N bits, where N is chosen on every request and may be anything from 1 to 32. A mode input picks the interpretation of the target field. In signed mode the limits are -2^(N-1) and 2^(N-1)-1. In unsigned mode the limits are 0 and 2^N-1. The clamped value is returned right-aligned in a 32-bit word, together with a flag that tells the caller whether clamping took place.

Signed results are sign-extended to 32 bits and unsigned results are zero-extended. This lets the word be written straight into a register file or passed on to a later stage. A single register stage sits between the combinational clamp and the outputs. Each accepted request produces exactly one valid output cycle, and the outputs keep their last values while no request arrives.

Top module: `sat_clamp_unit`

## Requirements
- R1: In signed mode (in_unsigned=0), an operand greater than 2^(N-1)-1 yields 2^(N-1)-1, sign-extended to 32 bits, with out_sat=1.
- R2: In signed mode, an operand less than -2^(N-1) yields -2^(N-1), sign-extended to 32 bits, with out_sat=1.
- R3: In unsigned mode (in_unsigned=1), an operand greater than 2^N-1 yields 2^N-1, zero-extended, with out_sat=1.
- R4: In unsigned mode, any negative operand (in_value bit 32 set) yields 0 with out_sat=1.
- R5: An operand inside the range of the selected mode is passed through with out_sat=0. It is sign-extended from bit N-1 in signed mode and zero-extended in unsigned mode.
- R6: An in_width of 0, or any in_width of 33 or more, is treated as N=32. Otherwise N equals in_width, read as an unsigned binary number.
- R7: out_valid is high in the cycle after each cycle with in_valid high, and low in the cycle after each cycle with in_valid low.
- R8: out_result and out_sat keep their values in the cycle after a cycle with in_valid low.
- R9: While rst_n is low, out_valid, out_result and out_sat are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe, one operand per high cycle |
| in_value | input | 33 | Operand, two's complement |
| in_width | input | 6 | Target width N, binary |
| in_unsigned | input | 1 | 1 selects the unsigned range, 0 the signed range |
| out_valid | output | 1 | Result valid, one cycle per request |
| out_result | output | 32 | Clamped value, extended to 32 bits |
| out_sat | output | 1 | 1 when the operand was clamped |

## Verification
Two functions can fall in the same cycle. In one, the output register captures a fresh request. In the other, it presents the previous one. The bench provokes this with back-to-back requests that differ in mode, width and outcome: a clamped signed operand is followed directly by an in-range unsigned one. Each output cycle is judged against its own request, which shows that neither the flag nor the extension leaks from one result into the next. The bench also pairs the width fallback with clamping in a single request, using a width of 0 and an operand just above 2^31-1. The expected result is the 32-bit signed limit with the flag set.

// File: rtl/sat_clamp_unit.sv
module sat_clamp_unit #(
  parameter int OUT_W  = 32,
  parameter int WSEL_W = $clog2(OUT_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OUT_W:0]    in_value,
  input  logic [WSEL_W-1:0] in_width,
  input  logic              in_unsigned,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_result,
  output logic              out_sat
);

  localparam int IN_W  = OUT_W + 1;
  localparam int CMP_W = IN_W + 1;
  localparam logic [WSEL_W-1:0] FULL_N = WSEL_W'(OUT_W);

  logic [WSEL_W-1:0]       n_eff;
  logic [CMP_W-1:0]        half_span;
  logic signed [CMP_W-1:0] val_x;
  logic signed [CMP_W-1:0] s_max;
  logic signed [CMP_W-1:0] s_min;
  logic signed [CMP_W-1:0] u_max;
  logic signed [CMP_W-1:0] hi_lim;
  logic signed [CMP_W-1:0] lo_lim;
  logic signed [CMP_W-1:0] clamped;
  logic                    above;
  logic                    below;

  assign n_eff = (in_width == '0 || in_width > FULL_N) ? FULL_N : in_width;

  assign val_x     = $signed({in_value[IN_W-1], in_value});
  assign half_span = CMP_W'(1) << (n_eff - WSEL_W'(1));
  assign s_max     = $signed(half_span - CMP_W'(1));
  assign s_min     = $signed(-half_span);
  assign u_max     = $signed((CMP_W'(1) << n_eff) - CMP_W'(1));

  assign hi_lim = in_unsigned ? u_max : s_max;
  assign lo_lim = in_unsigned ? '0    : s_min;

  assign above = val_x > hi_lim;
  assign below = val_x < lo_lim;

  always_comb begin
    if (above)      clamped = hi_lim;
    else if (below) clamped = lo_lim;
    else            clamped = val_x;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_sat    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= clamped[OUT_W-1:0];
        out_sat    <= above | below;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R7
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_result) && $stable(out_sat))); // R8
  AST_UNS_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_unsigned && in_value[IN_W-1]) |=> (out_sat && out_result == '0)); // R4
  AST_SGN_POS_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_unsigned && !in_value[IN_W-1]) |=> !out_result[OUT_W-1]); // R1
  AST_SGN_NEG_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_unsigned && in_value[IN_W-1]) |=> out_result[OUT_W-1]); // R2
  AST_ZERO_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_value == '0) |=> (!out_sat && out_result == '0)); // R5

endmodule

// File: tb/sim_sat_clamp_unit.sv
module sim_sat_clamp_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [32:0] in_value = '0;
  logic [5:0]  in_width = '0;
  logic        in_unsigned = 1'b0;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_sat;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sat_clamp_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
    .in_width(in_width), .in_unsigned(in_unsigned),
    .out_valid(out_valid), .out_result(out_result), .out_sat(out_sat)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input longint v, input int w, input bit u);
    in_valid    = 1'b1;
    in_value    = v[32:0];
    in_width    = w[5:0];
    in_unsigned = u;
  endtask

  task automatic send(input string req, input longint v, input int w, input bit u,
                      input logic [31:0] exp_r, input bit exp_s);
    @(negedge clk);
    drive(v, w, u);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, {31'd0, out_valid}, 32'd1);
    chk({req, " result"}, out_result, exp_r);
    chk({req, " flag"}, {31'd0, out_sat}, {31'd0, exp_s});
  endtask

  task automatic test_reset;
    @(negedge clk);
    chk("R9 valid", {31'd0, out_valid}, 32'd0);
    chk("R9 result", out_result, 32'd0);
    chk("R9 flag", {31'd0, out_sat}, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic test_signed_high;
    send("R1 n8", 200, 8, 1'b0, 32'h0000007F, 1'b1);
    send("R1 n32", 64'h0_FFFF_FFFF, 32, 1'b0, 32'h7FFFFFFF, 1'b1);
    send("R1 n1", 1, 1, 1'b0, 32'h00000000, 1'b1);
  endtask

  task automatic test_signed_low;
    send("R2 n8", -200, 8, 1'b0, 32'hFFFFFF80, 1'b1);
    send("R2 n1", -5, 1, 1'b0, 32'hFFFFFFFF, 1'b1);
    send("R2 n32", -64'sd4294967296, 32, 1'b0, 32'h80000000, 1'b1);
  endtask

  task automatic test_unsigned_high;
    send("R3 n8", 300, 8, 1'b1, 32'h000000FF, 1'b1);
    send("R3 n1", 2, 1, 1'b1, 32'h00000001, 1'b1);
    send("R3 n16", 65536, 16, 1'b1, 32'h0000FFFF, 1'b1);
  endtask

  task automatic test_unsigned_neg;
    send("R4 minus1", -1, 8, 1'b1, 32'h00000000, 1'b1);
    send("R4 most negative", -64'sd4294967296, 32, 1'b1, 32'h00000000, 1'b1);
  endtask

  task automatic test_in_range;
    send("R5 signed min n8", -128, 8, 1'b0, 32'hFFFFFF80, 1'b0);
    send("R5 signed max n8", 127, 8, 1'b0, 32'h0000007F, 1'b0);
    send("R5 signed n16 minus1", -1, 16, 1'b0, 32'hFFFFFFFF, 1'b0);
    send("R5 unsigned n8", 255, 8, 1'b1, 32'h000000FF, 1'b0);
    send("R5 unsigned n32", 64'h0_FFFF_FFFF, 32, 1'b1, 32'hFFFFFFFF, 1'b0);
    send("R5 unsigned n4 bit3", 9, 4, 1'b1, 32'h00000009, 1'b0);
  endtask

  task automatic test_width_fallback;
    send("R6 w0 clamp", 64'h0_8000_0000, 0, 1'b0, 32'h7FFFFFFF, 1'b1);
    send("R6 w40 unsigned", 64'h0_FFFF_FFFF, 40, 1'b1, 32'hFFFFFFFF, 1'b0);
    send("R6 w33 signed", 100000, 33, 1'b0, 32'h000186A0, 1'b0);
    send("R6 w63 negative", -70000, 63, 1'b0, 32'hFFFEEE90, 1'b0);
  endtask

  task automatic test_back_to_back;
    @(negedge clk);
    drive(-300, 8, 1'b0);
    @(negedge clk);
    chk("R7 first valid", {31'd0, out_valid}, 32'd1);
    chk("R7 first result", out_result, 32'hFFFFFF80);
    chk("R7 first flag", {31'd0, out_sat}, 32'd1);
    drive(5, 4, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 second valid", {31'd0, out_valid}, 32'd1);
    chk("R7 second result", out_result, 32'h00000005);
    chk("R7 second flag", {31'd0, out_sat}, 32'd0);
    @(negedge clk);
    chk("R7 idle valid", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic test_hold;
    send("R8 setup", 1000, 8, 1'b1, 32'h000000FF, 1'b1);
    in_value = 33'h1_0000_0000;
    in_width = 6'd3;
    in_unsigned = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 valid low", {31'd0, out_valid}, 32'd0);
    chk("R8 result held", out_result, 32'h000000FF);
    chk("R8 flag held", {31'd0, out_sat}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    test_reset();
    test_signed_high();
    test_signed_low();
    test_unsigned_high();
    test_unsigned_neg();
    test_in_range();
    test_width_fallback();
    test_back_to_back();
    test_hold();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule